// File: doc/BRIEF.md
# Big-endian load/store byte-lane unit

This block sits between a 32-bit processor core and a data memory that is one word wide. For a store, it takes an access size, the low byte-offset bits of the effective address and the register data. It returns a byte-lane enable mask and write data with the operand copied into the lanes that the access covers. For a load, it takes the word returned by memory and extracts the addressed byte, halfword or word. It then widens the value to a full 32-bit register result, with sign or zero extension as the load type asks.

Lane mapping is big-endian: byte offset 0 is the most significant byte of the memory word. Accesses must be naturally aligned. An access that breaks alignment is reported on an address-error flag, and its effect is cancelled. No lanes are enabled for such a store, and such a load returns zero. The effective address is formed outside the block, and only its low offset bits enter. The store path and the load path each register their outputs once, so every result appears on the clock edge after its request.

Top module: `be_lane_unit`

## Requirements
- R1: While reset is high at a clock edge, every output is driven to zero on that edge: lane mask, write data, both error flags, load valid and load value.
- R2: Each output reflects the request sampled on the previous edge. A cycle with no store request gives a zero lane mask and a clear store error. A cycle with no load request gives load valid low, a zero value and a clear load error. A cycle with a load request gives load valid high.
- R3: The size code is 2'b00 for byte, 2'b01 for halfword, and 2'b10 or 2'b11 for word. A byte store at offset k enables only mask bit 3-k. The write data holds the low store byte copied into all four lanes.
- R4: A halfword store at offset 0 gives mask 4'b1100, and at offset 2 it gives mask 4'b0011. The write data holds the low 16 store bits copied into both halves.
- R5: A word store at offset 0 gives mask 4'b1111, and the write data equals the store data unchanged.
- R6: A halfword store at an odd offset, or a word store at any nonzero offset, raises the store error and gives mask 4'b0000.
- R7: A byte load at offset k takes read-word bits [31-8k:24-8k] as bits [7:0] of the result.
- R8: A halfword load at offset 0 takes read bits [31:16], and at offset 2 it takes bits [15:0], as result bits [15:0]. A word load at offset 0 returns the read word unchanged.
- R9: With the unsigned input low, the bits above a byte or halfword result copy its top bit. With the unsigned input high, those bits are zero.
- R10: A misaligned load, using the same rule as R6, raises the load error and returns value zero while load valid is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_req | input | 1 | Store request this cycle |
| st_size | input | 2 | Store size code |
| st_offset | input | 2 | Low byte-offset bits of the store address |
| st_data | input | 32 | Store operand from the register file |
| wr_lanes_o | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| wr_data_o | output | 32 | Lane-aligned write data |
| st_misalign_o | output | 1 | Store address error |
| ld_req | input | 1 | Load request this cycle |
| ld_size | input | 2 | Load size code |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| ld_offset | input | 2 | Low byte-offset bits of the load address |
| rd_word | input | 32 | Word returned by memory |
| ld_valid_o | output | 1 | Load result valid |
| ld_value_o | output | 32 | Extended load result |
| ld_misalign_o | output | 1 | Load address error |

## Verification
The bench builds the block with its default 32-bit data width, which gives four byte lanes and a two-bit offset. This small space lets a directed sweep cover every size code, both extension modes and all offsets, including the reserved word code and every misaligned pairing. The read words are chosen so that the top bit of each extracted byte and halfword is sometimes set and sometimes clear. A further random run mixes idle cycles with store and load requests in the same cycle.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORDX = 2'b11
  } acc_size_e;

  // number of bytes an access covers; any code with bit 1 set is a full word
  function automatic int size_bytes(input logic [1:0] sz, input int full);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return full;
    endcase
  endfunction

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check #(
  parameter int OFF_W = 2
) (
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             bad_o
);
  always_comb begin
    case (size_i)
      lsu_lane_pkg::SZ_BYTE: bad_o = 1'b0;
      lsu_lane_pkg::SZ_HALF: bad_o = off_i[0];
      default:               bad_o = (off_i != '0);
    endcase
  end
endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BYTES-1:0]  lanes_o,
  output logic [DATA_W-1:0] data_o
);
  // lane i (bits 8i+7:8i) carries byte offset BYTES-1-i
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam int LOFF = BYTES - 1 - i;
    int         nb;
    int         o;
    logic       en;
    logic [7:0] byte_d;
    always_comb begin
      nb     = lsu_lane_pkg::size_bytes(size_i, BYTES);
      o      = int'(off_i);
      en     = (LOFF >= o) && (LOFF < o + nb);
      // first offset inside an item holds its most significant byte
      byte_d = data_i[8*(nb - 1 - (LOFF % nb)) +: 8];
    end
    assign lanes_o[i]       = en;
    assign data_o[8*i +: 8] = byte_d;
  end
endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] value_o
);
  logic fill;

  // top bit of the item sits in bit 7 of the byte at the start offset
  always_comb begin
    fill = ~unsigned_i & word_i[8*(BYTES - 1 - int'(off_i)) + 7];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_res
    int         nb;
    int         pos;
    logic [7:0] byte_d;
    always_comb begin
      nb  = lsu_lane_pkg::size_bytes(size_i, BYTES);
      pos = (int'(off_i) + nb - 1 - b) & (BYTES - 1);
      if (b < nb) byte_d = word_i[8*(BYTES - 1 - pos) +: 8];
      else        byte_d = {8{fill}};
    end
    assign value_o[8*b +: 8] = byte_d;
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_req,
  input  logic [1:0]        st_size,
  input  logic [OFF_W-1:0]  st_offset,
  input  logic [DATA_W-1:0] st_data,
  output logic [BYTES-1:0]  wr_lanes_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              st_misalign_o,
  input  logic              ld_req,
  input  logic [1:0]        ld_size,
  input  logic              ld_unsigned,
  input  logic [OFF_W-1:0]  ld_offset,
  input  logic [DATA_W-1:0] rd_word,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_value_o,
  output logic              ld_misalign_o
);
  logic              st_bad, ld_bad;
  logic [BYTES-1:0]  st_lanes;
  logic [DATA_W-1:0] st_steered;
  logic [DATA_W-1:0] ld_ext;

  lane_align_check #(.OFF_W(OFF_W)) u_st_align (
    .size_i(st_size), .off_i(st_offset), .bad_o(st_bad)
  );

  lane_align_check #(.OFF_W(OFF_W)) u_ld_align (
    .size_i(ld_size), .off_i(ld_offset), .bad_o(ld_bad)
  );

  store_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size_i(st_size), .off_i(st_offset), .data_i(st_data),
    .lanes_o(st_lanes), .data_o(st_steered)
  );

  load_lane_extract #(.DATA_W(DATA_W)) u_extract (
    .size_i(ld_size), .off_i(ld_offset), .unsigned_i(ld_unsigned),
    .word_i(rd_word), .value_o(ld_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_lanes_o    <= '0;
      wr_data_o     <= '0;
      st_misalign_o <= 1'b0;
    end else begin
      wr_lanes_o    <= (st_req && !st_bad) ? st_lanes : '0;
      wr_data_o     <= st_steered;
      st_misalign_o <= st_req && st_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid_o    <= 1'b0;
      ld_value_o    <= '0;
      ld_misalign_o <= 1'b0;
    end else begin
      ld_valid_o    <= ld_req;
      ld_value_o    <= (ld_req && !ld_bad) ? ld_ext : '0;
      ld_misalign_o <= ld_req && ld_bad;
    end
  end
endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              st_req,
  input logic [1:0]        st_size,
  input logic [OFF_W-1:0]  st_offset,
  input logic [DATA_W-1:0] st_data,
  input logic [BYTES-1:0]  wr_lanes_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              st_misalign_o,
  input logic              ld_req,
  input logic [1:0]        ld_size,
  input logic              ld_unsigned,
  input logic [OFF_W-1:0]  ld_offset,
  input logic [DATA_W-1:0] rd_word,
  input logic              ld_valid_o,
  input logic [DATA_W-1:0] ld_value_o,
  input logic              ld_misalign_o
);
  logic st_odd, ld_odd;
  assign st_odd = (st_size == 2'b01 && st_offset[0]) || (st_size[1] && st_offset != '0);
  assign ld_odd = (ld_size == 2'b01 && ld_offset[0]) || (ld_size[1] && ld_offset != '0);

  a_r2_store_idle: assert property (@(posedge clk) disable iff (rst)
    !st_req |=> (wr_lanes_o == '0) && !st_misalign_o);

  a_r2_load_idle: assert property (@(posedge clk) disable iff (rst)
    !ld_req |=> !ld_valid_o && (ld_value_o == '0) && !ld_misalign_o);

  a_r2_load_valid: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> ld_valid_o);

  a_r3_byte_onehot: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_size == 2'b00) |=> ($countones(wr_lanes_o) == 1) && !st_misalign_o);

  a_r4_half_pair: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_size == 2'b01 && !st_offset[0]) |=> $countones(wr_lanes_o) == 2);

  a_r5_word_full: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_size[1] && st_offset == '0) |=>
      (wr_lanes_o == '1) && (wr_data_o == $past(st_data)));

  a_r6_store_misalign: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_odd) |=> st_misalign_o && (wr_lanes_o == '0));

  a_r8_word_load: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_size[1] && ld_offset == '0) |=> ld_value_o == $past(rd_word));

  a_r9_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_unsigned && ld_size == 2'b00) |=> ld_value_o[DATA_W-1:8] == '0);

  a_r9_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !ld_unsigned && ld_size == 2'b00) |=>
      ld_value_o[DATA_W-1:8] == {(DATA_W-8){ld_value_o[7]}});

  a_r10_load_misalign: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_odd) |=> ld_misalign_o && ld_valid_o && (ld_value_o == '0));
endmodule

bind be_lane_unit be_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/be_lane_unit_tb.sv
module be_lane_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_req = 1'b0, ld_req = 1'b0, ld_unsigned = 1'b0;
  logic [1:0]  st_size = '0, ld_size = '0, st_offset = '0, ld_offset = '0;
  logic [31:0] st_data = '0, rd_word = '0;
  logic [3:0]  wr_lanes_o;
  logic [31:0] wr_data_o, ld_value_o;
  logic        st_misalign_o, ld_valid_o, ld_misalign_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  be_lane_unit u_dut (.*);

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // expected values, captured at the sampling edge
  logic        e_sreq, e_sbad, e_lreq, e_lbad;
  logic [3:0]  e_lanes;
  logic [31:0] e_wdata, e_val;
  int          e_snb, e_lnb;

  task automatic model_edge();
    int off, nb;
    logic [31:0] v;
    e_sreq = st_req; e_lreq = ld_req;
    nb = nbytes(st_size); off = int'(st_offset); e_snb = nb;
    e_sbad = (off % nb) != 0;
    e_lanes = '0;
    for (int k = off; k < off + nb && k < 4; k++) e_lanes[3-k] = 1'b1;
    if (nb == 1)      e_wdata = {4{st_data[7:0]}};
    else if (nb == 2) e_wdata = {2{st_data[15:0]}};
    else              e_wdata = st_data;
    nb = nbytes(ld_size); off = int'(ld_offset); e_lnb = nb;
    e_lbad = (off % nb) != 0;
    v = rd_word >> (8 * (4 - off - nb));
    if (nb == 1)      v = ld_unsigned ? {24'h0, v[7:0]}  : {{24{v[7]}}, v[7:0]};
    else if (nb == 2) v = ld_unsigned ? {16'h0, v[15:0]} : {{16{v[15]}}, v[15:0]};
    e_val = v;
  endtask

  task automatic compare();
    logic [31:0] m;
    if (!e_sreq)
      chk("R2 store idle", wr_lanes_o == 4'h0 && !st_misalign_o, {27'h0, st_misalign_o, wr_lanes_o}, 32'h0);
    else if (e_sbad)
      chk("R6 store misaligned", wr_lanes_o == 4'h0 && st_misalign_o, {27'h0, st_misalign_o, wr_lanes_o}, 32'h10);
    else begin
      string t;
      t = (e_snb == 1) ? "R3 byte store" : (e_snb == 2) ? "R4 half store" : "R5 word store";
      chk({t, " lanes"}, wr_lanes_o == e_lanes && !st_misalign_o, {27'h0, st_misalign_o, wr_lanes_o}, {28'h0, e_lanes});
      chk({t, " data"}, wr_data_o == e_wdata, wr_data_o, e_wdata);
    end
    chk("R2 load valid", ld_valid_o == e_lreq, {31'h0, ld_valid_o}, {31'h0, e_lreq});
    if (!e_lreq)
      chk("R2 load idle", ld_value_o == 0 && !ld_misalign_o, ld_value_o, 32'h0);
    else if (e_lbad)
      chk("R10 load misaligned", ld_value_o == 0 && ld_misalign_o, ld_value_o, 32'h0);
    else begin
      m = (e_lnb == 4) ? 32'hFFFF_FFFF : (32'h1 << (8 * e_lnb)) - 1;
      chk((e_lnb == 1) ? "R7 byte lane" : "R8 half/word lane",
          (ld_value_o & m) == (e_val & m) && !ld_misalign_o, ld_value_o & m, e_val & m);
      if (e_lnb < 4)
        chk("R9 extension", (ld_value_o & ~m) == (e_val & ~m), ld_value_o & ~m, e_val & ~m);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset lanes/flags", wr_lanes_o == 0 && !st_misalign_o && !ld_valid_o && !ld_misalign_o,
        {26'h0, ld_misalign_o, ld_valid_o, st_misalign_o, 1'b0, wr_lanes_o[1:0]}, 32'h0);
    chk("R1 reset data", wr_data_o == 0 && ld_value_o == 0, wr_data_o | ld_value_o, 32'h0);
    rst = 1'b0;
    step();
    // directed sweep: every size code, offset and extension mode
    for (int pat = 0; pat < 2; pat++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int u = 0; u < 2; u++) begin
            st_req = 1'b1; st_size = 2'(sz); st_offset = 2'(off);
            st_data = pat ? 32'h1357_9BDF : 32'hA1B2_C3D4;
            ld_req = 1'b1; ld_size = 2'(sz); ld_offset = 2'(off); ld_unsigned = 1'(u);
            rd_word = pat ? 32'h7F01_FF80 : 32'h80F1_7E02;
            step();
          end
    st_req = 1'b0; ld_req = 1'b0;
    step();
    for (int n = 0; n < 400; n++) begin
      st_req = 1'($urandom_range(0, 1)); st_size = 2'($urandom_range(0, 3));
      st_offset = 2'($urandom_range(0, 3)); st_data = $urandom;
      ld_req = 1'($urandom_range(0, 1)); ld_size = 2'($urandom_range(0, 3));
      ld_offset = 2'($urandom_range(0, 3)); ld_unsigned = 1'($urandom_range(0, 1));
      rd_word = $urandom;
      step();
    end
    st_req = 1'b0; ld_req = 1'b0;
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule